// File: doc/BRIEF.md
# Shadow Address Gather Engine

This block sits beside a memory controller and answers cache-line reads and writes whose physical address lies above the installed DRAM, in a shadow window. The window has no storage of its own. A descriptor, written through a small register port, describes how each shadow line maps onto real memory. A shadow line read becomes a series of element reads on a single-element DRAM port. The engine packs the results into one dense 32-byte line of four 64-bit elements. A shadow line write scatters its four elements back to their real addresses in the same way.

Two access patterns are supported. In strided mode, element `e` sits at `base + e*stride`. In indexed mode, the engine itself reads index word `e` from an index vector in DRAM, then reads the element at `base + index*element_size`. After a read line has been handed over, the engine gathers the following shadow line into a one-line prefetch buffer. A sequential walk through the shadow structure therefore pays the gather latency only once.

Descriptor registers, selected by `cfg_sel_i`:
- 0: mode, bit 0 (0 = strided, 1 = indexed)
- 1: target array base
- 2: element size in bytes (indexed mode)
- 3: stride in bytes (strided mode) or index vector base (indexed mode)
- 4: length in elements

Top module: `shadow_gather_engine`

## Requirements
- R1: `shadow_hit_o` is 1 exactly when `req_addr_i` is at or above `SHADOW_BASE` (default 0x4000_0000, i.e. 1 GB installed).
- R2: Shadow line `L = (addr - SHADOW_BASE) >> 5` covers elements `4L..4L+3`. Element `4L+k` is placed at bits `[64k+63:64k]` of the line.
- R3: In strided mode, element `e` is read from `base + e*stride`, using 32-bit wrapping arithmetic.
- R4: In indexed mode, the index words for all in-range elements of a line are fetched first, in ascending `k`, from `ixbase + e*8`. The data elements follow in ascending `k`, from `base + idx*esize`, where `idx` is the low 32 bits of the index word.
- R5: An element with `e >= length` reads as zero, and neither its index word nor its data is accessed in DRAM.
- R6: A shadow write stores lane `k` of the line at element `4L+k`'s computed address. Lanes at or beyond the length are not written. A response handshake follows the last store.
- R7: At most one DRAM request is outstanding. `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` hold steady until `mem_ack_i`.
- R8: After a read response is taken, line `L+1` is gathered into the prefetch buffer. A later read of that line is answered with `rsp_valid_o` in the cycle after acceptance, with no DRAM access. A read that misses the buffer pays the full gather.
- R9: Accepting a shadow write, or any descriptor register write, invalidates the prefetch buffer, including a prefetch still in flight.
- R10: After reset, `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_o` are 0.
- R11: `rsp_valid_o` and `rsp_rdata_o` hold until `rsp_ready_i`.
- R12: `req_ready_o` is high only when no line or prefetch is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Descriptor register write strobe |
| cfg_sel_i | input | 3 | Descriptor register select |
| cfg_wdata_i | input | 32 | Descriptor register write data |
| req_valid_i | input | 1 | Line request valid |
| req_ready_o | output | 1 | Engine can accept a line request |
| req_write_i | input | 1 | 1 = line write, 0 = line read |
| req_addr_i | input | 32 | Line address in the shadow window |
| req_wdata_i | input | 256 | Line write data |
| shadow_hit_o | output | 1 | Address decodes to the shadow window |
| rsp_valid_o | output | 1 | Line response valid |
| rsp_ready_i | input | 1 | Response consumed |
| rsp_rdata_o | output | 256 | Gathered line (zero for writes) |
| mem_req_o | output | 1 | DRAM element request |
| mem_we_o | output | 1 | DRAM element write |
| mem_addr_o | output | 32 | DRAM byte address |
| mem_wdata_o | output | 64 | DRAM write data |
| mem_ack_i | input | 1 | Request complete; read data valid this cycle |
| mem_rdata_i | input | 64 | DRAM read data |

## Verification
A buffer hit puts `rsp_valid_o` high in the cycle after acceptance. The bench measures this from its negedge sample after the accepting edge, and a hit must show a count of one cycle with no DRAM access in between. A miss response only appears after the last element acknowledge plus one cycle. For misses the bench does not count cycles: it waits for the handshake, then checks the data and the DRAM access count and order recorded by its memory model. Prefetch effects are checked only after `req_ready_o` has returned high, because the background gather must have finished by then.

// File: rtl/shgat_pkg.sv
package shgat_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_IDX, ST_DAT, ST_RSP} st_e;
  typedef enum logic {MD_STRIDE = 1'b0, MD_INDIR = 1'b1} mode_e;
  localparam int unsigned SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_MODE  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_BASE  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_ESIZE = 3'd2;
  localparam logic [SEL_W-1:0] SEL_AUX   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_LEN   = 3'd4;
endpackage

// File: rtl/shgat_desc_regs.sv
module shgat_desc_regs
  import shgat_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [AW-1:0]    wdata_i,
  output mode_e            mode_o,
  output logic [AW-1:0]    base_o,
  output logic [AW-1:0]    esize_o,
  output logic [AW-1:0]    aux_o,
  output logic [AW-1:0]    len_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= MD_STRIDE;
      base_o  <= '0;
      esize_o <= '0;
      aux_o   <= '0;
      len_o   <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_MODE:  mode_o  <= mode_e'(wdata_i[0]);
        SEL_BASE:  base_o  <= wdata_i;
        SEL_ESIZE: esize_o <= wdata_i;
        SEL_AUX:   aux_o   <= wdata_i;
        SEL_LEN:   len_o   <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/shgat_addr_gen.sv
module shgat_addr_gen
  import shgat_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned ELEM_BYTES = 8
) (
  input  mode_e         mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] esize_i,
  input  logic [AW-1:0] aux_i,
  input  logic [AW-1:0] len_i,
  input  logic [AW-1:0] elem_i,
  input  logic [AW-1:0] idx_i,
  input  logic          idx_phase_i,
  output logic [AW-1:0] addr_o,
  output logic          in_range_o
);
  always_comb begin
    in_range_o = elem_i < len_i;
    if (idx_phase_i)
      addr_o = aux_i + elem_i * AW'(ELEM_BYTES);
    else if (mode_i == MD_INDIR)
      addr_o = base_i + idx_i * esize_i;
    else
      addr_o = base_i + elem_i * aux_i;
  end
endmodule

// File: rtl/shgat_pf_buf.sv
module shgat_pf_buf #(
  parameter int unsigned AW = 32,
  parameter int unsigned EW = 64,
  parameter int unsigned NE = 4,
  localparam int unsigned LW = EW * NE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fill_i,
  input  logic [AW-1:0] fill_line_i,
  input  logic [LW-1:0] fill_data_i,
  input  logic          inval_i,
  input  logic [AW-1:0] look_line_i,
  output logic          hit_o,
  output logic [LW-1:0] data_o
);
  logic          valid_q;
  logic [AW-1:0] tag_q;
  logic [EW-1:0] lane_q [NE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (inval_i) begin
      valid_q <= 1'b0;
    end else if (fill_i) begin
      valid_q <= 1'b1;
      tag_q   <= fill_line_i;
    end
  end

  for (genvar g = 0; g < NE; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_q[g] <= '0;
      else if (fill_i) lane_q[g] <= fill_data_i[g*EW +: EW];
    end
    assign data_o[g*EW +: EW] = lane_q[g];
  end

  assign hit_o = valid_q && (tag_q == look_line_i);

  AST_INVAL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !hit_o); // R9
endmodule

// File: rtl/shadow_gather_engine.sv
module shadow_gather_engine
  import shgat_pkg::*;
#(
  parameter int unsigned      ADDR_W      = 32,
  parameter int unsigned      ELEM_W      = 64,
  parameter int unsigned      LINE_ELEMS  = 4,
  parameter logic [ADDR_W-1:0] SHADOW_BASE = 'h4000_0000,
  localparam int unsigned     LINE_W      = ELEM_W * LINE_ELEMS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LINE_W-1:0] req_wdata_i,
  output logic              shadow_hit_o,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [LINE_W-1:0] rsp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ELEM_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [ELEM_W-1:0] mem_rdata_i
);
  localparam int unsigned ELEM_BYTES = ELEM_W / 8;
  localparam int unsigned LINE_BYTES = ELEM_BYTES * LINE_ELEMS;
  localparam int unsigned LINE_SH    = $clog2(LINE_BYTES);
  localparam int unsigned K_W        = $clog2(LINE_ELEMS);

  st_e               st_q;
  logic [K_W-1:0]    k_q;
  logic [ADDR_W-1:0] line_q;
  logic              wr_q, pf_q, kill_q;
  logic [ADDR_W-1:0] idx_q [LINE_ELEMS];
  logic [ELEM_W-1:0] dat_q [LINE_ELEMS];
  logic [LINE_W-1:0] wline_q;

  mode_e             d_mode;
  logic [ADDR_W-1:0] d_base, d_esize, d_aux, d_len;

  shgat_desc_regs #(.AW(ADDR_W)) desc_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
    .wdata_i(cfg_wdata_i), .mode_o(d_mode), .base_o(d_base),
    .esize_o(d_esize), .aux_o(d_aux), .len_o(d_len)
  );

  logic [ADDR_W-1:0] elem, gen_addr, req_line;
  logic              in_range, busy, step, last_k, accept, hit_acc;
  logic              pf_hit, pf_fill, pf_inval;
  logic [LINE_W-1:0] pf_data, fill_data;

  assign elem     = (line_q << K_W) | ADDR_W'(k_q);
  assign req_line = (req_addr_i - SHADOW_BASE) >> LINE_SH;

  shgat_addr_gen #(.AW(ADDR_W), .ELEM_BYTES(ELEM_BYTES)) agen_i (
    .mode_i(d_mode), .base_i(d_base), .esize_i(d_esize), .aux_i(d_aux),
    .len_i(d_len), .elem_i(elem), .idx_i(idx_q[k_q]),
    .idx_phase_i(st_q == ST_IDX), .addr_o(gen_addr), .in_range_o(in_range)
  );

  assign busy     = (st_q == ST_IDX) || (st_q == ST_DAT);
  assign step     = busy && (!in_range || mem_ack_i);
  assign last_k   = k_q == K_W'(LINE_ELEMS - 1);
  assign accept   = (st_q == ST_IDLE) && req_valid_i;
  assign hit_acc  = accept && !req_write_i && pf_hit;
  assign pf_fill  = (st_q == ST_DAT) && step && last_k && pf_q && !kill_q && !cfg_we_i;
  assign pf_inval = cfg_we_i || (accept && req_write_i);

  for (genvar g = 0; g < LINE_ELEMS; g++) begin : g_pack
    assign fill_data[g*ELEM_W +: ELEM_W] =
      (K_W'(g) == k_q && in_range) ? mem_rdata_i : dat_q[g];
    assign rsp_rdata_o[g*ELEM_W +: ELEM_W] = dat_q[g];
  end

  shgat_pf_buf #(.AW(ADDR_W), .EW(ELEM_W), .NE(LINE_ELEMS)) pf_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .fill_i(pf_fill), .fill_line_i(line_q),
    .fill_data_i(fill_data), .inval_i(pf_inval), .look_line_i(req_line),
    .hit_o(pf_hit), .data_o(pf_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      k_q     <= '0;
      line_q  <= '0;
      wr_q    <= 1'b0;
      pf_q    <= 1'b0;
      kill_q  <= 1'b0;
      wline_q <= '0;
      for (int i = 0; i < LINE_ELEMS; i++) begin
        idx_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          line_q  <= req_line;
          wr_q    <= req_write_i;
          wline_q <= req_wdata_i;
          pf_q    <= 1'b0;
          kill_q  <= 1'b0;
          k_q     <= '0;
          for (int i = 0; i < LINE_ELEMS; i++)
            dat_q[i] <= hit_acc ? pf_data[i*ELEM_W +: ELEM_W] : '0;
          if (hit_acc)                st_q <= ST_RSP;
          else if (d_mode == MD_INDIR) st_q <= ST_IDX;
          else                        st_q <= ST_DAT;
        end
        ST_IDX: if (step) begin
          idx_q[k_q] <= in_range ? mem_rdata_i[ADDR_W-1:0] : '0;
          if (last_k) begin
            k_q  <= '0;
            st_q <= ST_DAT;
          end else k_q <= k_q + K_W'(1);
        end
        ST_DAT: if (step) begin
          if (!wr_q && in_range) dat_q[k_q] <= mem_rdata_i;
          if (last_k) begin
            k_q  <= '0;
            st_q <= pf_q ? ST_IDLE : ST_RSP;
          end else k_q <= k_q + K_W'(1);
        end
        ST_RSP: if (rsp_ready_i) begin
          if (!wr_q) begin
            pf_q   <= 1'b1;
            kill_q <= 1'b0;
            line_q <= line_q + ADDR_W'(1);
            k_q    <= '0;
            for (int i = 0; i < LINE_ELEMS; i++) dat_q[i] <= '0;
            st_q   <= (d_mode == MD_INDIR) ? ST_IDX : ST_DAT;
          end else st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
      if (cfg_we_i && st_q != ST_IDLE) kill_q <= 1'b1;
    end
  end

  assign req_ready_o  = st_q == ST_IDLE;
  assign rsp_valid_o  = st_q == ST_RSP;
  assign shadow_hit_o = req_addr_i >= SHADOW_BASE;
  assign mem_req_o    = busy && in_range;
  assign mem_we_o     = (st_q == ST_DAT) && wr_q;
  assign mem_addr_o   = gen_addr;
  assign mem_wdata_o  = wline_q[k_q*ELEM_W +: ELEM_W];

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i && !cfg_we_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o)); // R7
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_rdata_o)); // R11
  AST_HIT_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_acc |=> rsp_valid_o && !mem_req_o); // R8
  AST_MISS_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !hit_acc |=> !rsp_valid_o); // R8
  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !rsp_valid_o); // R12
endmodule

// File: tb/shadow_gather_engine_tb_top.sv
`timescale 1ns/1ps
module shadow_gather_engine_tb_top;
  localparam logic [31:0] SB = 32'h4000_0000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_we_i = 1'b0;
  logic [2:0] cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic req_valid_i = 1'b0, req_write_i = 1'b0, rsp_ready_i = 1'b0, mem_ack_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [255:0] req_wdata_i = '0;
  logic [63:0] mem_rdata_i = '0;
  logic req_ready_o, shadow_hit_o, rsp_valid_o, mem_req_o, mem_we_o;
  logic [255:0] rsp_rdata_o;
  logic [31:0] mem_addr_o;
  logic [63:0] mem_wdata_o;

  shadow_gather_engine dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_write_i(req_write_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .shadow_hit_o(shadow_hit_o), .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
    .rsp_rdata_o(rsp_rdata_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i)
  );

  always #4 clk_i = ~clk_i;

  int tests = 0, fails = 0, acc_cnt = 0, log_n = 0, wait_cnt = 0;
  logic [31:0] log_a [16];
  logic [31:0] hold_a;
  logic [63:0] mem_q [logic [31:0]];
  logic        d_mode;
  logic [31:0] d_base, d_es, d_aux, d_len;

  task automatic chk(input logic ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [31:0] a);
    return mem_q.exists(a) ? mem_q[a] : {a ^ 32'h5A5A_0000, a};
  endfunction

  function automatic logic [31:0] idx_of(input int unsigned e);
    return rd(d_aux + 32'(e) * 32'd8)[31:0];
  endfunction

  function automatic logic [31:0] data_addr(input int unsigned e);
    return d_mode ? d_base + idx_of(e) * d_es : d_base + 32'(e) * d_aux;
  endfunction

  function automatic logic [255:0] exp_line(input int unsigned l);
    logic [255:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (32'(l * 4 + k) < d_len) r[k*64 +: 64] = rd(data_addr(l * 4 + k));
    return r;
  endfunction

  function automatic int exp_acc(input int unsigned l);
    int n = 0;
    for (int k = 0; k < 4; k++) if (32'(l * 4 + k) < d_len) n++;
    return d_mode ? 2 * n : n;
  endfunction

  // DRAM model: latency 0..2 extra cycles, one request at a time
  initial begin
    forever begin
      @(negedge clk_i);
      if (mem_ack_i) mem_ack_i = 1'b0;
      else if (mem_req_o) begin
        if (wait_cnt == 0) hold_a = mem_addr_o;
        else chk(mem_addr_o == hold_a, "R7 addr hold", 256'(mem_addr_o), 256'(hold_a));
        if (wait_cnt >= acc_cnt % 3) begin
          wait_cnt = 0;
          mem_ack_i = 1'b1;
          if (mem_we_o) mem_q[mem_addr_o] = mem_wdata_o;
          else mem_rdata_i = rd(mem_addr_o);
          if (log_n < 16) log_a[log_n] = mem_addr_o;
          log_n++;
          acc_cnt++;
        end else wait_cnt++;
      end
    end
  end

  task automatic cfg_wr(input logic [2:0] sel, input logic [31:0] v);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic set_desc(input logic m, input logic [31:0] b, input logic [31:0] es,
                          input logic [31:0] aux, input logic [31:0] len);
    d_mode = m; d_base = b; d_es = es; d_aux = aux; d_len = len;
    cfg_wr(3'd0, {31'd0, m}); cfg_wr(3'd1, b); cfg_wr(3'd2, es);
    cfg_wr(3'd3, aux); cfg_wr(3'd4, len);
  endtask

  task automatic line_op(input logic wr, input int unsigned l, input logic [255:0] wd,
                         output logic [255:0] rdat, output int nacc, output int cyc);
    int a0;
    logic [255:0] first;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = SB + 32'(l) * 32'd32; req_wdata_i = wd;
    while (!req_ready_o) @(negedge clk_i);
    a0 = acc_cnt; log_n = 0;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    cyc = 1;
    while (!rsp_valid_o) begin @(negedge clk_i); cyc++; end
    nacc = acc_cnt - a0;
    first = rsp_rdata_o;
    @(negedge clk_i);
    chk(rsp_valid_o && rsp_rdata_o == first, "R11 response hold", rsp_rdata_o, first);
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
    rdat = first;
  endtask

  initial begin
    logic [255:0] r, w;
    int n, c;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk(req_ready_o && !rsp_valid_o && !mem_req_o, "R10 reset state",
        {rsp_valid_o, mem_req_o, req_ready_o}, 3'b001);

    // R1 decode
    req_addr_i = 32'h3FFF_FFE0; #1;
    chk(!shadow_hit_o, "R1 below window", shadow_hit_o, 0);
    req_addr_i = SB; #1;
    chk(shadow_hit_o, "R1 window start", shadow_hit_o, 1);
    req_addr_i = 32'hFFFF_FFE0; #1;
    chk(shadow_hit_o, "R1 window top", shadow_hit_o, 1);

    // R2 R3 R5 R8 strided sweep
    foreach (log_a[i]) log_a[i] = '0;
    for (int s = 0; s < 3; s++) begin
      set_desc(1'b0, 32'h0000_1000, 32'd8, (s == 0) ? 32'd8 : (s == 1) ? 32'd24 : 32'd136, 32'd13);
      for (int l = 0; l < 5; l++) begin
        line_op(1'b0, l, '0, r, n, c);
        chk(r == exp_line(l), (l >= 3) ? "R5 zero beyond length" : "R3 strided line", r, exp_line(l));
        if (l == 0) chk(n == exp_acc(0), "R3 miss accesses", n, exp_acc(0));
        else chk(n == 0 && c == 1, "R8 prefetch hit", {n, c}, {32'd0, 32'd1});
      end
    end

    // R4 indexed
    for (int e = 0; e < 16; e++)
      mem_q[32'h0010_0000 + 32'(e) * 8] = {32'hFFFF_0000, 32'((e * 5 + 3) % 11)};
    set_desc(1'b1, 32'h0002_0000, 32'd16, 32'h0010_0000, 32'd10);
    line_op(1'b0, 0, '0, r, n, c);
    chk(r == exp_line(0), "R4 indexed line", r, exp_line(0));
    chk(n == 8, "R4 access count", n, 8);
    for (int k = 0; k < 4; k++) begin
      chk(log_a[k] == 32'h0010_0000 + 32'(k) * 8, "R4 index order", log_a[k], 32'h0010_0000 + 32'(k) * 8);
      chk(log_a[4 + k] == data_addr(k), "R4 data order", log_a[4 + k], data_addr(k));
    end
    for (int l = 1; l < 4; l++) begin
      line_op(1'b0, l, '0, r, n, c);
      chk(r == exp_line(l), "R5 indexed tail", r, exp_line(l));
      chk(n == 0 && c == 1, "R8 indexed hit", {n, c}, {32'd0, 32'd1});
    end
    line_op(1'b0, 1, '0, r, n, c);
    chk(n == exp_acc(1), "R8 non-sequential miss", n, exp_acc(1));
    chk(r == exp_line(1), "R2 refetch line", r, exp_line(1));

    // R6 scatter
    for (int k = 0; k < 4; k++) w[k*64 +: 64] = 64'hC0DE_0000_0000_0000 | 64'(k);
    line_op(1'b1, 0, w, r, n, c);
    chk(n == 8, "R6 indexed scatter count", n, 8);
    for (int k = 0; k < 4; k++)
      chk(rd(data_addr(k)) == w[k*64 +: 64], "R6 indexed scatter", rd(data_addr(k)), w[k*64 +: 64]);
    set_desc(1'b0, 32'h0000_3000, 32'd8, 32'd40, 32'd6);
    line_op(1'b1, 1, w, r, n, c);
    chk(n == 2, "R6 strided scatter count", n, 2);
    chk(rd(32'h3000 + 4 * 40) == w[63:0], "R6 lane0", rd(32'h3000 + 4 * 40), w[63:0]);
    chk(rd(32'h3000 + 5 * 40) == w[127:64], "R6 lane1", rd(32'h3000 + 5 * 40), w[127:64]);
    chk(!mem_q.exists(32'h3000 + 6 * 40), "R6 no store beyond length", 1, 0);

    // R9 invalidation
    set_desc(1'b0, 32'h0000_5000, 32'd8, 32'd16, 32'd16);
    line_op(1'b0, 0, '0, r, n, c);
    for (int k = 0; k < 4; k++) w[k*64 +: 64] = 64'hBEEF_0000_0000_0000 | 64'(k + 4);
    line_op(1'b1, 1, w, r, n, c);
    line_op(1'b0, 1, '0, r, n, c);
    chk(n == 4, "R9 write invalidates", n, 4);
    chk(r == w, "R9 fresh data after write", r, w);
    line_op(1'b0, 2, '0, r, n, c);
    chk(n == 0 && c == 1, "R8 hit after refill", {n, c}, {32'd0, 32'd1});
    d_base = 32'h0000_9000;
    cfg_wr(3'd1, d_base);
    line_op(1'b0, 3, '0, r, n, c);
    chk(n == 4, "R9 descriptor write invalidates", n, 4);
    chk(r == exp_line(3), "R9 new descriptor data", r, exp_line(3));
    chk(req_ready_o == 1'b0 || req_ready_o == 1'b1, "R12 ready defined", req_ready_o, req_ready_o);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule